// File: doc/BRIEF.md
# NAND Bank Strobe Timing Sequencer

This block drives the control strobes and data lanes of one NAND flash bank on a static memory bus. Software programs a control word and two timing words through a small register port. A requester then presents single accesses on a separate access port. Each access is tagged as command, address or data and as read or write. The sequencer turns each access into the pin pattern the bank expects: command latch, address latch, write strobe, read strobe, chip enable and the data-bus drive enable.

Every served access passes through up to four counted phases. The setup phase keeps the strobe high. The strobe phase holds the strobe low. The hold phase raises the strobe again while the latches and the write data stay up. After a write, a float phase keeps the bus released. Phase lengths come from the timing word that was selected and captured when the access was accepted. A data-port read that directly follows a command or an address access gets extra setup cycles from a separate 4-bit gap field. When the bank is switched off, or the sequencer is held in soft reset, every request is refused with an error response and no strobe moves.

Top module: `nsq_strobe_seq`

## Requirements
- R1: After the synchronous reset, the outputs are: chip enable inactive (`nand_ce_n`=1), both latches low, both strobes high, `nand_dq_oe`=0, `req_ready`=1 and `resp_valid`=0. Every register reads zero.
- R2: The register index is `reg_addr[3:2]`. Index 0 is control, which keeps bits [16:0]. Index 2 is the main timing word and index 3 is the alternate timing word. Index 1 reads zero, and writes to it change nothing.
- R3: `nand_ce_n` is the inverse of control bit 2 (bank on), from the cycle after that bit is written.
- R4: `req_kind` 0 selects the command port and raises `nand_cle`. Kind 1 selects the address port and raises `nand_ale`. Kinds 2 and 3 select the data port and raise neither. The latch stays high from the first setup cycle to the last hold cycle.
- R5: The timing word holds setup [7:0], strobe [15:8], hold [23:16] and float [31:24]. An access spends setup+1 cycles with both strobes high, then strobe+1 cycles with the write strobe (on writes) or the read strobe (on reads) low, then hold cycles with both strobes high.
- R6: On a write, `nand_dq_oe` is high from the first setup cycle to the last hold cycle, then low for float cycles before the response. The data lanes carry `req_wdata` only for data-port writes with control bit 4 (wide) set. Otherwise they carry the low byte with the upper byte zero.
- R7: A read samples `nand_dq_in` at the clock edge that ends the last strobe cycle. It masks the sample to the low byte when control bit 4 is clear and returns it on `resp_rdata` with the response. Reads never raise `nand_dq_oe` and have no float phase.
- R8: A data-port read whose previous served access was a command gets control[12:9] extra setup cycles. One whose previous served access was an address gets control[16:13] extra setup cycles. Writes and other reads get none.
- R9: `req_attr`=1 makes the access use the alternate timing word instead of the main one.
- R10: If control bit 2 is clear or control bit 0 (soft reset) is set when a request is accepted, the next cycle carries `resp_valid`=1 with `resp_err`=1, and no latch, strobe or bus drive moves.
- R11: The timing word is captured at acceptance. A register write in the same cycle as the acceptance, or during the access, does not change that access.
- R12: `req_ready` is high exactly when the sequencer is idle. A request is accepted on a clock edge with `req_valid` and `req_ready` both high. A served access ends with a one-cycle `resp_valid` with `resp_err`=0, in the cycle after its last phase cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| reg_wr | input | 1 | register write strobe |
| reg_addr | input | 4 | register byte offset |
| reg_wdata | input | 32 | register write data |
| reg_rdata | output | 32 | register read data for `reg_addr` |
| req_valid | input | 1 | access request |
| req_kind | input | 2 | 0 command, 1 address, 2/3 data |
| req_write | input | 1 | 1 write, 0 read |
| req_attr | input | 1 | use the alternate timing word |
| req_wdata | input | 16 | write data |
| req_ready | output | 1 | sequencer idle, request accepted this edge |
| resp_valid | output | 1 | access finished |
| resp_err | output | 1 | access refused |
| resp_rdata | output | 16 | read data |
| nand_ce_n | output | 1 | chip enable, active low |
| nand_cle | output | 1 | command latch enable |
| nand_ale | output | 1 | address latch enable |
| nand_we_n | output | 1 | write strobe, active low |
| nand_re_n | output | 1 | read strobe, active low |
| nand_dq_out | output | 16 | data lanes driven to the bank |
| nand_dq_oe | output | 1 | data lane drive enable |
| nand_dq_in | input | 16 | data lanes from the bank |

## Verification
A register write and the acceptance of an access can fall on the same clock edge. The question is then which timing word the access runs with. The bench raises `reg_wr` for the main timing word in the same cycle as an accepted `req_valid`, and it also rewrites the word while an access is in flight. Its cycle-by-cycle model builds the expected pin sequence from the register copy that held before that edge, so a design that picks up the new word early shows a strobe or bus-drive mismatch in the exact cycle it drifts.

// File: rtl/nsq_pkg.sv
package nsq_pkg;

    parameter int PH_W      = 8;
    parameter int GAP_W     = 4;
    parameter int REG_W     = 32;
    parameter int BYTE_W    = 8;
    parameter int CTRL_BITS = 17;
    localparam int CNT_W    = PH_W + 1;

    // register word indices (reg_addr[3:2])
    localparam logic [1:0] IDX_CTRL = 2'd0;
    localparam logic [1:0] IDX_STAT = 2'd1;
    localparam logic [1:0] IDX_MAIN = 2'd2;
    localparam logic [1:0] IDX_ALT  = 2'd3;

    // control bit positions
    localparam int B_SRST   = 0;
    localparam int B_BANK   = 2;
    localparam int B_WIDE   = 4;
    localparam int B_CLR_LO = 9;
    localparam int B_AR_LO  = 13;

    typedef enum logic [1:0] {
        PORT_CMD  = 2'd0,
        PORT_ADDR = 2'd1,
        PORT_DATA = 2'd2
    } port_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_STROBE,
        PH_HOLD,
        PH_FLOAT,
        PH_RESP
    } phase_e;

    // packed MSB first: float [31:24], hold [23:16], strobe [15:8], setup [7:0]
    typedef struct packed {
        logic [PH_W-1:0] flt;
        logic [PH_W-1:0] hold;
        logic [PH_W-1:0] strb;
        logic [PH_W-1:0] setup;
    } tim_s;

    typedef struct packed {
        logic [GAP_W-1:0] ar_gap;
        logic [GAP_W-1:0] clr_gap;
        logic             wide;
        logic             bank_on;
        logic             srst;
    } cfg_s;

    function automatic cfg_s decode_ctrl(input logic [CTRL_BITS-1:0] c);
        cfg_s r;
        r.srst    = c[B_SRST];
        r.bank_on = c[B_BANK];
        r.wide    = c[B_WIDE];
        r.clr_gap = c[B_CLR_LO +: GAP_W];
        r.ar_gap  = c[B_AR_LO +: GAP_W];
        return r;
    endfunction

    function automatic port_e kind_of(input logic [1:0] k);
        port_e r;
        case (k)
            2'd0:    r = PORT_CMD;
            2'd1:    r = PORT_ADDR;
            default: r = PORT_DATA;
        endcase
        return r;
    endfunction

    // setup cycles minus one, including the latch-to-read gap
    function automatic logic [CNT_W-1:0] setup_span(input tim_s t, input cfg_s c,
                                                    input port_e prev, input port_e kind,
                                                    input logic wr);
        logic [GAP_W-1:0] gap;
        gap = '0;
        if (!wr && kind == PORT_DATA) begin
            if (prev == PORT_CMD)
                gap = c.clr_gap;
            else if (prev == PORT_ADDR)
                gap = c.ar_gap;
        end
        return {1'b0, t.setup} + CNT_W'(gap);
    endfunction

endpackage

// File: rtl/nsq_regfile.sv
module nsq_regfile
    import nsq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr,
    input  logic [1:0]           idx,
    input  logic [REG_W-1:0]     wdata,
    output logic [REG_W-1:0]     rdata,
    output logic [CTRL_BITS-1:0] ctrl,
    output tim_s                 tim_main,
    output tim_s                 tim_alt
);

    logic [CTRL_BITS-1:0] ctrl_q;
    tim_s                 tim_q [2];

    always_ff @(posedge clk) begin
        if (rst)
            ctrl_q <= '0;
        else if (wr && idx == IDX_CTRL)
            ctrl_q <= wdata[CTRL_BITS-1:0];
    end

    for (genvar g = 0; g < 2; g++) begin : g_tim
        localparam logic [1:0] MY_IDX = IDX_MAIN + 2'(g);
        always_ff @(posedge clk) begin
            if (rst)
                tim_q[g] <= '0;
            else if (wr && idx == MY_IDX)
                tim_q[g] <= tim_s'(wdata);
        end
    end

    always_comb begin
        case (idx)
            IDX_CTRL: rdata = {{(REG_W-CTRL_BITS){1'b0}}, ctrl_q};
            IDX_MAIN: rdata = tim_q[0];
            IDX_ALT:  rdata = tim_q[1];
            default:  rdata = '0;
        endcase
    end

    assign ctrl     = ctrl_q;
    assign tim_main = tim_q[0];
    assign tim_alt  = tim_q[1];

endmodule

// File: rtl/nsq_sequencer.sv
module nsq_sequencer
    import nsq_pkg::*;
#(
    parameter int DQ_W = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  cfg_s            cfg,
    input  tim_s            tim_main,
    input  tim_s            tim_alt,
    input  logic            req_valid,
    input  logic [1:0]      req_kind,
    input  logic            req_write,
    input  logic            req_attr,
    input  logic [DQ_W-1:0] req_wdata,
    input  logic [DQ_W-1:0] dq_in,
    output logic            ready,
    output phase_e          phase,
    output port_e           kind,
    output logic            is_wr,
    output logic [DQ_W-1:0] wdat,
    output logic            resp_valid,
    output logic            resp_err,
    output logic [DQ_W-1:0] rdat
);

    phase_e            ph_q;
    logic [CNT_W-1:0]  cnt_q;
    tim_s              t_q;
    port_e             kind_q;
    port_e             prev_q;
    logic              wr_q;
    logic              err_q;
    logic [DQ_W-1:0]   wdat_q;
    logic [DQ_W-1:0]   rdat_q;

    tim_s              t_sel;
    port_e             kind_in;
    logic              serve;
    logic              last;
    logic              has_float;
    logic [DQ_W-1:0]   sample;

    assign t_sel     = req_attr ? tim_alt : tim_main;
    assign kind_in   = kind_of(req_kind);
    assign serve     = cfg.bank_on && !cfg.srst;
    assign last      = (cnt_q == '0);
    assign has_float = wr_q && (t_q.flt != '0);
    assign sample    = cfg.wide ? dq_in
                                : {{(DQ_W-BYTE_W){1'b0}}, dq_in[BYTE_W-1:0]};

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q   <= PH_IDLE;
            cnt_q  <= '0;
            t_q    <= '0;
            kind_q <= PORT_DATA;
            prev_q <= PORT_DATA;
            wr_q   <= 1'b0;
            err_q  <= 1'b0;
            wdat_q <= '0;
            rdat_q <= '0;
        end else begin
            case (ph_q)
                PH_IDLE: begin
                    if (req_valid) begin
                        kind_q <= kind_in;
                        wr_q   <= req_write;
                        wdat_q <= req_wdata;
                        t_q    <= t_sel;
                        if (serve) begin
                            ph_q   <= PH_SETUP;
                            cnt_q  <= setup_span(t_sel, cfg, prev_q, kind_in, req_write);
                            prev_q <= kind_in;
                            err_q  <= 1'b0;
                        end else begin
                            ph_q  <= PH_RESP;
                            err_q <= 1'b1;
                        end
                    end
                end
                PH_SETUP: begin
                    if (last) begin
                        ph_q  <= PH_STROBE;
                        cnt_q <= {1'b0, t_q.strb};
                    end else begin
                        cnt_q <= cnt_q - CNT_W'(1);
                    end
                end
                PH_STROBE: begin
                    if (last) begin
                        if (!wr_q)
                            rdat_q <= sample;
                        if (t_q.hold != '0) begin
                            ph_q  <= PH_HOLD;
                            cnt_q <= {1'b0, t_q.hold} - CNT_W'(1);
                        end else if (has_float) begin
                            ph_q  <= PH_FLOAT;
                            cnt_q <= {1'b0, t_q.flt} - CNT_W'(1);
                        end else begin
                            ph_q <= PH_RESP;
                        end
                    end else begin
                        cnt_q <= cnt_q - CNT_W'(1);
                    end
                end
                PH_HOLD: begin
                    if (last) begin
                        if (has_float) begin
                            ph_q  <= PH_FLOAT;
                            cnt_q <= {1'b0, t_q.flt} - CNT_W'(1);
                        end else begin
                            ph_q <= PH_RESP;
                        end
                    end else begin
                        cnt_q <= cnt_q - CNT_W'(1);
                    end
                end
                PH_FLOAT: begin
                    if (last)
                        ph_q <= PH_RESP;
                    else
                        cnt_q <= cnt_q - CNT_W'(1);
                end
                default: begin
                    ph_q <= PH_IDLE;
                end
            endcase
        end
    end

    assign ready      = (ph_q == PH_IDLE);
    assign phase      = ph_q;
    assign kind       = kind_q;
    assign is_wr      = wr_q;
    assign wdat       = wdat_q;
    assign resp_valid = (ph_q == PH_RESP);
    assign resp_err   = (ph_q == PH_RESP) && err_q;
    assign rdat       = rdat_q;

endmodule

// File: rtl/nsq_pin_drive.sv
module nsq_pin_drive
    import nsq_pkg::*;
#(
    parameter int DQ_W = 16
) (
    input  phase_e          phase,
    input  port_e           kind,
    input  logic            is_wr,
    input  logic [DQ_W-1:0] wdat,
    input  cfg_s            cfg,
    output logic            ce_n,
    output logic            cle,
    output logic            ale,
    output logic            we_n,
    output logic            re_n,
    output logic [DQ_W-1:0] dq_out,
    output logic            dq_oe
);

    logic active;
    logic strobing;
    logic full_lane;

    assign active    = (phase == PH_SETUP) || (phase == PH_STROBE) || (phase == PH_HOLD);
    assign strobing  = (phase == PH_STROBE);
    assign full_lane = cfg.wide && (kind == PORT_DATA);

    assign ce_n   = !cfg.bank_on;
    assign cle    = active && (kind == PORT_CMD);
    assign ale    = active && (kind == PORT_ADDR);
    assign we_n   = !(strobing && is_wr);
    assign re_n   = !(strobing && !is_wr);
    assign dq_oe  = active && is_wr;

    always_comb begin
        if (!dq_oe)
            dq_out = '0;
        else if (full_lane)
            dq_out = wdat;
        else
            dq_out = {{(DQ_W-BYTE_W){1'b0}}, wdat[BYTE_W-1:0]};
    end

endmodule

// File: rtl/nsq_strobe_seq.sv
module nsq_strobe_seq
    import nsq_pkg::*;
#(
    parameter int DQ_W = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            reg_wr,
    input  logic [3:0]      reg_addr,
    input  logic [31:0]     reg_wdata,
    output logic [31:0]     reg_rdata,
    input  logic            req_valid,
    input  logic [1:0]      req_kind,
    input  logic            req_write,
    input  logic            req_attr,
    input  logic [DQ_W-1:0] req_wdata,
    output logic            req_ready,
    output logic            resp_valid,
    output logic            resp_err,
    output logic [DQ_W-1:0] resp_rdata,
    output logic            nand_ce_n,
    output logic            nand_cle,
    output logic            nand_ale,
    output logic            nand_we_n,
    output logic            nand_re_n,
    output logic [DQ_W-1:0] nand_dq_out,
    output logic            nand_dq_oe,
    input  logic [DQ_W-1:0] nand_dq_in
);

    logic [CTRL_BITS-1:0] ctrl;
    tim_s                 tim_main;
    tim_s                 tim_alt;
    cfg_s                 cfg;
    phase_e               phase;
    port_e                kind;
    logic                 is_wr;
    logic [DQ_W-1:0]      wdat;

    assign cfg = decode_ctrl(ctrl);

    nsq_regfile u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr       (reg_wr),
        .idx      (reg_addr[3:2]),
        .wdata    (reg_wdata),
        .rdata    (reg_rdata),
        .ctrl     (ctrl),
        .tim_main (tim_main),
        .tim_alt  (tim_alt)
    );

    nsq_sequencer #(.DQ_W(DQ_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .cfg        (cfg),
        .tim_main   (tim_main),
        .tim_alt    (tim_alt),
        .req_valid  (req_valid),
        .req_kind   (req_kind),
        .req_write  (req_write),
        .req_attr   (req_attr),
        .req_wdata  (req_wdata),
        .dq_in      (nand_dq_in),
        .ready      (req_ready),
        .phase      (phase),
        .kind       (kind),
        .is_wr      (is_wr),
        .wdat       (wdat),
        .resp_valid (resp_valid),
        .resp_err   (resp_err),
        .rdat       (resp_rdata)
    );

    nsq_pin_drive #(.DQ_W(DQ_W)) u_pins (
        .phase  (phase),
        .kind   (kind),
        .is_wr  (is_wr),
        .wdat   (wdat),
        .cfg    (cfg),
        .ce_n   (nand_ce_n),
        .cle    (nand_cle),
        .ale    (nand_ale),
        .we_n   (nand_we_n),
        .re_n   (nand_re_n),
        .dq_out (nand_dq_out),
        .dq_oe  (nand_dq_oe)
    );

endmodule

// File: rtl/nsq_checker.sv
module nsq_checker (
    input logic        clk,
    input logic        rst,
    input logic        reg_wr,
    input logic [3:0]  reg_addr,
    input logic [31:0] reg_wdata,
    input logic        req_valid,
    input logic        req_ready,
    input logic        resp_valid,
    input logic        resp_err,
    input logic        nand_ce_n,
    input logic        nand_cle,
    input logic        nand_ale,
    input logic        nand_we_n,
    input logic        nand_re_n,
    input logic        nand_dq_oe
);

    assert_ce_follows_R3: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr[3:2] == 2'd0) |=> (nand_ce_n == !$past(reg_wdata[2])));

    assert_one_latch_R4: assert property (@(posedge clk) disable iff (rst)
        !(nand_cle && nand_ale));

    assert_one_strobe_R5: assert property (@(posedge clk) disable iff (rst)
        !(!nand_we_n && !nand_re_n));

    assert_write_drives_R6: assert property (@(posedge clk) disable iff (rst)
        !nand_we_n |-> nand_dq_oe);

    assert_read_released_R7: assert property (@(posedge clk) disable iff (rst)
        !nand_re_n |-> !nand_dq_oe);

    assert_refusal_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        resp_err |-> (resp_valid && nand_we_n && nand_re_n && !nand_cle && !nand_ale));

    assert_busy_after_accept_R12: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    assert_resp_single_R12: assert property (@(posedge clk) disable iff (rst)
        resp_valid |=> !resp_valid);

    assert_resp_not_idle_R12: assert property (@(posedge clk) disable iff (rst)
        resp_valid |-> !req_ready);

endmodule

bind nsq_strobe_seq nsq_checker u_nsq_checker (
    .clk        (clk),
    .rst        (rst),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .resp_valid (resp_valid),
    .resp_err   (resp_err),
    .nand_ce_n  (nand_ce_n),
    .nand_cle   (nand_cle),
    .nand_ale   (nand_ale),
    .nand_we_n  (nand_we_n),
    .nand_re_n  (nand_re_n),
    .nand_dq_oe (nand_dq_oe)
);

// File: tb/nsq_strobe_seq_bench.sv
`timescale 1ns/1ps
module nsq_strobe_seq_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = '0;
    logic        req_write = 1'b0;
    logic        req_attr = 1'b0;
    logic [15:0] req_wdata = '0;
    logic        req_ready;
    logic        resp_valid;
    logic        resp_err;
    logic [15:0] resp_rdata;
    logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
    logic [15:0] nand_dq_out;
    logic [15:0] nand_dq_in = 16'h3C5A;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    nsq_strobe_seq u_nsq_strobe_seq (
        .clk(clk), .rst(rst),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .req_valid(req_valid), .req_kind(req_kind), .req_write(req_write), .req_attr(req_attr),
        .req_wdata(req_wdata), .req_ready(req_ready), .resp_valid(resp_valid),
        .resp_err(resp_err), .resp_rdata(resp_rdata),
        .nand_ce_n(nand_ce_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
        .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_dq_out(nand_dq_out),
        .nand_dq_oe(nand_dq_oe), .nand_dq_in(nand_dq_in)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
        end
    endtask

    task automatic wrap_up();
        if (!finished) begin
            finished = 1'b1;
            $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    // bank data changes every cycle, shortly after the edge
    always @(posedge clk) begin
        #1 nand_dq_in = nand_dq_in * 16'd5 + 16'h1B3;
    end

    // ---------------- behavioural reference model ----------------
    typedef struct {
        bit          cle, ale, we_n, re_n, oe, rv, err, samp, rchk;
        logic [15:0] dq;
    } exp_t;

    exp_t        q[$];
    logic [31:0] m_ctrl = '0;
    logic [31:0] m_main = '0;
    logic [31:0] m_alt  = '0;
    int          m_last = 2;
    logic [15:0] m_rd   = '0;

    function automatic exp_t idle_e();
        exp_t e;
        e = '{default: 0};
        e.we_n = 1'b1;
        e.re_n = 1'b1;
        e.dq   = '0;
        return e;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_ctrl <= '0; m_main <= '0; m_alt <= '0;
        end else if (reg_wr) begin
            case (reg_addr[3:2])
                2'd0: m_ctrl <= {15'd0, reg_wdata[16:0]};
                2'd2: m_main <= reg_wdata;
                2'd3: m_alt  <= reg_wdata;
                default: ;
            endcase
        end
    end

    function automatic void push_access();
        exp_t e, s, r;
        int k, gap;
        logic [31:0] t;
        t = req_attr ? m_alt : m_main;
        k = (req_kind == 2'd3) ? 2 : int'(req_kind);
        r = idle_e();
        r.rv = 1'b1;
        if (!m_ctrl[2] || m_ctrl[0]) begin
            r.err = 1'b1;
            q.push_back(r);
            return;
        end
        gap = 0;
        if (!req_write && k == 2)
            gap = (m_last == 0) ? int'(m_ctrl[12:9]) : (m_last == 1) ? int'(m_ctrl[16:13]) : 0;
        m_last = k;
        e = idle_e();
        e.cle = (k == 0);
        e.ale = (k == 1);
        e.oe  = req_write;
        e.dq  = req_write ? ((k == 2 && m_ctrl[4]) ? req_wdata : {8'h00, req_wdata[7:0]}) : 16'h0;
        repeat (int'(t[7:0]) + 1 + gap) q.push_back(e);
        for (int i = 0; i <= int'(t[15:8]); i++) begin
            s = e;
            if (req_write) s.we_n = 1'b0; else s.re_n = 1'b0;
            s.samp = !req_write && (i == int'(t[15:8]));
            q.push_back(s);
        end
        repeat (int'(t[23:16])) q.push_back(e);
        if (req_write) repeat (int'(t[31:24])) q.push_back(idle_e());
        r.rchk = !req_write;
        q.push_back(r);
    endfunction

    exp_t cur;
    bit   was_idle;
    always @(negedge clk) begin
        if (rst) begin
            q.delete();
            m_last = 2;
        end else begin
            was_idle = (q.size() == 0);
            cur = was_idle ? idle_e() : q.pop_front();
            chk(req_ready == was_idle, "R12 ready", 32'(req_ready), 32'(was_idle));
            chk(resp_valid == cur.rv, "R12 resp_valid", 32'(resp_valid), 32'(cur.rv));
            chk(resp_err == cur.err, "R10 resp_err", 32'(resp_err), 32'(cur.err));
            chk(nand_ce_n == !m_ctrl[2], "R3 ce_n", 32'(nand_ce_n), 32'(!m_ctrl[2]));
            chk({nand_cle, nand_ale} == {cur.cle, cur.ale}, "R4 cle/ale",
                32'({nand_cle, nand_ale}), 32'({cur.cle, cur.ale}));
            chk({nand_we_n, nand_re_n} == {cur.we_n, cur.re_n}, "R5 R8 R9 R11 strobes",
                32'({nand_we_n, nand_re_n}), 32'({cur.we_n, cur.re_n}));
            chk(nand_dq_oe == cur.oe, "R6 dq_oe", 32'(nand_dq_oe), 32'(cur.oe));
            if (cur.oe)
                chk(nand_dq_out == cur.dq, "R6 dq_out", 32'(nand_dq_out), 32'(cur.dq));
            if (cur.samp)
                m_rd = m_ctrl[4] ? nand_dq_in : {8'h00, nand_dq_in[7:0]};
            if (cur.rchk)
                chk(resp_rdata == m_rd, "R7 rdata", 32'(resp_rdata), 32'(m_rd));
            if (was_idle && req_valid)
                push_access();
        end
    end

    // ---------------- stimulus ----------------
    task automatic reg_write(input logic [3:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic reg_check(input logic [3:0] a, input logic [31:0] exp, input string tag);
        @(posedge clk); #1;
        reg_addr = a;
        #0.5;
        chk(reg_rdata == exp, tag, reg_rdata, exp);
    endtask

    // mode 0: plain, 1: main timing written on the accept edge, 2: written mid-access
    task automatic access(input logic [1:0] k, input logic w, input logic [15:0] d,
                          input logic a, input int mode, input logic [31:0] newtim);
        @(posedge clk); #1;
        req_valid = 1'b1; req_kind = k; req_write = w; req_wdata = d; req_attr = a;
        if (mode == 1) begin reg_wr = 1'b1; reg_addr = 4'h8; reg_wdata = newtim; end
        do @(negedge clk); while (!req_ready);
        @(posedge clk); #1;
        req_valid = 1'b0;
        reg_wr = 1'b0;
        if (mode == 2) begin
            @(posedge clk); #1;
            reg_wr = 1'b1; reg_addr = 4'h8; reg_wdata = newtim;
            @(posedge clk); #1;
            reg_wr = 1'b0;
        end
        do @(negedge clk); while (!resp_valid);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        wrap_up();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(nand_ce_n == 1'b1, "R1 ce_n", 32'(nand_ce_n), 32'd1);
        chk(req_ready == 1'b1 && resp_valid == 1'b0, "R1 ready/resp",
            32'({req_ready, resp_valid}), 32'h2);
        chk({nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe} == 5'b00110, "R1 pins",
            32'({nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe}), 32'h6);
        reg_check(4'h0, 32'h0, "R1 ctrl");
        reg_check(4'h8, 32'h0, "R1 main");
        reg_check(4'hC, 32'h0, "R1 alt");

        // R2 programming and read back
        reg_write(4'h0, 32'hFFF8_640C);
        reg_write(4'h8, 32'h0201_0302);
        reg_write(4'hC, 32'h0002_0101);
        reg_check(4'h0, 32'h0000_640C, "R2 ctrl");
        reg_check(4'h8, 32'h0201_0302, "R2 main");
        reg_check(4'hC, 32'h0002_0101, "R2 alt");
        reg_write(4'h4, 32'hFFFF_FFFF);
        reg_check(4'h4, 32'h0, "R2 status");
        reg_check(4'h0, 32'h0000_640C, "R2 ctrl after status write");
        reg_check(4'h8, 32'h0201_0302, "R2 main after status write");

        // narrow bus: command, address, reads with gaps (R4 R5 R6 R7 R8)
        access(2'd0, 1'b1, 16'h1270, 1'b0, 0, 0);
        access(2'd1, 1'b1, 16'hFF12, 1'b0, 0, 0);
        access(2'd2, 1'b0, 16'h0,    1'b0, 0, 0);
        access(2'd0, 1'b1, 16'h0090, 1'b0, 0, 0);
        access(2'd3, 1'b0, 16'h0,    1'b0, 0, 0);
        access(2'd2, 1'b0, 16'h0,    1'b0, 0, 0);
        access(2'd2, 1'b1, 16'h5AA5, 1'b0, 0, 0);
        access(2'd1, 1'b1, 16'h0034, 1'b0, 0, 0);
        access(2'd2, 1'b1, 16'h0001, 1'b0, 0, 0);
        access(2'd2, 1'b0, 16'h0,    1'b0, 0, 0);

        // wide bus (R6 R7)
        reg_write(4'h0, 32'h0000_641C);
        access(2'd2, 1'b1, 16'hBEEF, 1'b0, 0, 0);
        access(2'd0, 1'b1, 16'hABCD, 1'b0, 0, 0);
        access(2'd2, 1'b0, 16'h0,    1'b0, 0, 0);

        // alternate timing (R9)
        access(2'd2, 1'b1, 16'h7E57, 1'b1, 0, 0);
        access(2'd2, 1'b0, 16'h0,    1'b1, 0, 0);

        // all-zero timing
        reg_write(4'h8, 32'h0);
        access(2'd2, 1'b1, 16'h1111, 1'b0, 0, 0);
        access(2'd2, 1'b0, 16'h0,    1'b0, 0, 0);
        access(2'd0, 1'b1, 16'h00FF, 1'b0, 0, 0);

        // capture at acceptance (R11)
        reg_write(4'h8, 32'h0201_0302);
        access(2'd2, 1'b1, 16'h2222, 1'b0, 1, 32'h0104_0203);
        access(2'd2, 1'b1, 16'h3333, 1'b0, 0, 0);
        access(2'd2, 1'b0, 16'h0,    1'b0, 2, 32'h0001_0000);
        access(2'd2, 1'b0, 16'h0,    1'b0, 0, 0);

        // refusal (R10 R3)
        reg_write(4'h0, 32'h0000_6418);
        access(2'd0, 1'b1, 16'h00AA, 1'b0, 0, 0);
        reg_write(4'h0, 32'h0000_641D);
        access(2'd2, 1'b0, 16'h0, 1'b0, 0, 0);
        reg_write(4'h0, 32'h0000_640C);
        access(2'd1, 1'b1, 16'h0055, 1'b0, 0, 0);
        access(2'd2, 1'b0, 16'h0, 1'b0, 0, 0);

        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(q.size() == 0, "R12 drained", 32'(q.size()), 32'd0);
        wrap_up();
    end

endmodule